// File: doc/BRIEF.md
# Per-ID Packet-Counting FIFO

This block is a synchronous first-in first-out buffer for packetised beats. Every beat carries a data word, an end-of-packet marker and a small stream tag. The tag is stored with the beat, and packets with different tags may arrive interleaved at the input. The buffer keeps bookkeeping for each tag. A packet balance rises when an end-of-packet beat is written and falls when the opening beat of a packet leaves. A beat balance follows every write and every read of that tag. A downstream consumer or a checker can compare the two balances for any tag through a selection input.

The opening beat of a packet is not marked on the way in. The block works it out on the read side. For each tag, the first beat to leave after reset is an opening beat, and so is any beat of that tag that leaves after an end-of-packet beat of the same tag. The block reports this on `out_first`. The fill level is tracked by a three-state occupancy machine:

- EMPTY to PARTIAL on a write.
- PARTIAL to FULL on a write without a read while one slot is free.
- PARTIAL to EMPTY on a read without a write while one beat is held.
- FULL to PARTIAL on a read.

In every other case the machine holds its state. The input handshake and the output handshake both come from this state.

Top module: `pktcnt_fifo`

## Requirements
- R1: `in_ready` is 1 exactly when fewer than DEPTH beats are held. `out_valid` is 1 exactly when at least one beat is held.
- R2: Beats leave in the order they were accepted. `out_data`, `out_last` and `out_id` of the head beat equal the values presented with that beat at the input.
- R3: A beat offered while `in_ready` is 0 is not stored, and `out_ready` while `out_valid` is 0 removes nothing. The stored contents and the counts stay as they were.
- R4: `out_first` is 1 for the head beat when no beat of the same tag has left since reset, or when the last beat of that tag to leave had `out_last` set. Otherwise it is 0. Each tag is tracked separately.
- R5: Accepting an input beat with `in_last` set raises the packet balance of its tag by one.
- R6: A departing beat with `out_first` set lowers the packet balance of its tag by one. The balance may reach -1 while a packet's head has left and its tail has not yet arrived.
- R7: When an end-of-packet write and an opening-beat read of the same tag happen in one cycle, that tag's packet balance is unchanged.
- R8: The beat balance of a tag rises by one per accepted beat of that tag and falls by one per departing beat of that tag. A write and a read of the same tag in one cycle leave it unchanged.
- R9: `sel_pkt_count` (two's complement) and `sel_beat_count` show the balances of the tag on `sel_id` without delay. `sel_whole` is 1 exactly when `sel_pkt_count` is greater than zero.
- R10: Reset empties the buffer and zeroes every balance. It also makes the next departure of every tag an opening beat.
- R11: The occupancy machine moves among EMPTY, PARTIAL and FULL only by the transitions listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Buffer can take a beat |
| in_data | input | DATA_W | Input payload |
| in_last | input | 1 | Input beat ends its packet |
| in_id | input | ID_W | Input stream tag |
| out_valid | output | 1 | Head beat available |
| out_ready | input | 1 | Consumer takes the head beat |
| out_data | output | DATA_W | Head payload |
| out_last | output | 1 | Head beat ends its packet |
| out_id | output | ID_W | Head stream tag |
| out_first | output | 1 | Head beat opens its packet |
| sel_id | input | ID_W | Tag whose balances are shown |
| sel_pkt_count | output | ID-independent, DEPTH bits: $clog2(DEPTH)+2 | Signed packet balance of the selected tag |
| sel_beat_count | output | $clog2(DEPTH)+1 | Beat balance of the selected tag |
| sel_whole | output | 1 | Selected tag holds at least one complete packet |

## Verification
Handshake outputs and the head beat, including `out_first`, are combinational from registered state. The bench drives each cycle's inputs at the falling edge and compares them 1 ns later, before the rising edge that consumes them. Balances change on the rising edge that accepts or releases a beat. The bench reads them 1 ns after that edge by stepping `sel_id` through all tags, because the selection path has no register. A reference queue and per-tag balances, updated from the observed handshakes, supply every expected value. Each directed scenario also checks fixed numbers at its critical cycle.

// File: rtl/pktcnt_pkg.sv
package pktcnt_pkg;

    // Occupancy states of the buffer.
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    // Width of a level counter able to hold 0..depth.
    function automatic int level_width(input int depth);
        return $clog2(depth) + 1;
    endfunction

endpackage

// File: rtl/pktcnt_store.sv
module pktcnt_store #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [WORD_W-1:0]            wdata,
    output logic [WORD_W-1:0]            rdata,
    output logic [$clog2(DEPTH):0]       level
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W:0]    wr_ptr;
    logic [PTR_W:0]    rd_ptr;

    // Pointers carry one extra wrap bit so full and empty differ.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[PTR_W-1:0]] <= wdata;
    end

    assign rdata = mem[rd_ptr[PTR_W-1:0]];
    assign level = wr_ptr - rd_ptr;

endmodule

// File: rtl/pktcnt_occ_fsm.sv
module pktcnt_occ_fsm
    import pktcnt_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] level,
    output occ_state_e       state,
    output logic             in_ready,
    output logic             out_valid
);
    localparam logic [LVL_W-1:0] LVL_ONE     = LVL_W'(1);
    localparam logic [LVL_W-1:0] LVL_NEAR    = LVL_W'(DEPTH - 1);

    occ_state_e state_q;
    occ_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push) state_d = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (push && !pop && level == LVL_NEAR)
                    state_d = OCC_FULL;
                else if (pop && !push && level == LVL_ONE)
                    state_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (pop) state_d = OCC_PARTIAL;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // Outputs.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   begin in_ready = 1'b1; out_valid = 1'b0; end
            OCC_PARTIAL: begin in_ready = 1'b1; out_valid = 1'b1; end
            OCC_FULL:    begin in_ready = 1'b0; out_valid = 1'b1; end
            default:     begin in_ready = 1'b0; out_valid = 1'b0; end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/pktcnt_id_bank.sv
module pktcnt_id_bank #(
    parameter int ID_W  = 2,
    parameter int LVL_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  logic [ID_W-1:0]         push_id,
    input  logic                    push_last,
    input  logic                    pop,
    input  logic [ID_W-1:0]         pop_id,
    input  logic                    pop_last,
    input  logic [ID_W-1:0]         sel_id,
    output logic                    pop_first,
    output logic signed [LVL_W:0]   sel_pkt,
    output logic [LVL_W-1:0]        sel_beats,
    output logic                    sel_whole
);
    localparam int NUM_ID = 1 << ID_W;
    localparam int PC_W   = LVL_W + 1;

    logic signed [PC_W-1:0] pkt_q   [NUM_ID];
    logic [LVL_W-1:0]       beat_q  [NUM_ID];
    logic [NUM_ID-1:0]      first_q;

    for (genvar g = 0; g < NUM_ID; g++) begin : g_tag
        logic hit_in;
        logic hit_out;
        logic pkt_up;
        logic pkt_dn;

        assign hit_in  = push && (push_id == ID_W'(g));
        assign hit_out = pop  && (pop_id  == ID_W'(g));
        assign pkt_up  = hit_in  && push_last;
        assign pkt_dn  = hit_out && first_q[g];

        // Packet balance: end-of-packet in, opening beat out.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pkt_q[g] <= '0;
            end else begin
                unique case ({pkt_up, pkt_dn})
                    2'b10:   pkt_q[g] <= pkt_q[g] + PC_W'(1);
                    2'b01:   pkt_q[g] <= pkt_q[g] - PC_W'(1);
                    default: pkt_q[g] <= pkt_q[g];
                endcase
            end
        end

        // Beat balance.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                beat_q[g] <= '0;
            end else begin
                unique case ({hit_in, hit_out})
                    2'b10:   beat_q[g] <= beat_q[g] + LVL_W'(1);
                    2'b01:   beat_q[g] <= beat_q[g] - LVL_W'(1);
                    default: beat_q[g] <= beat_q[g];
                endcase
            end
        end

        // Opening-beat recovery on the read side.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       first_q[g] <= 1'b1;
            else if (hit_out) first_q[g] <= pop_last;
        end
    end

    assign pop_first = first_q[pop_id];
    assign sel_pkt   = pkt_q[sel_id];
    assign sel_beats = beat_q[sel_id];
    assign sel_whole = !sel_pkt[PC_W-1] && (sel_pkt != '0);

endmodule

// File: rtl/pktcnt_fifo.sv
module pktcnt_fifo
    import pktcnt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ID_W   = 2,
    parameter int DEPTH  = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [DATA_W-1:0]                  in_data,
    input  logic                               in_last,
    input  logic [ID_W-1:0]                    in_id,
    output logic                               out_valid,
    input  logic                               out_ready,
    output logic [DATA_W-1:0]                  out_data,
    output logic                               out_last,
    output logic [ID_W-1:0]                    out_id,
    output logic                               out_first,
    input  logic [ID_W-1:0]                    sel_id,
    output logic signed [$clog2(DEPTH)+1:0]    sel_pkt_count,
    output logic [$clog2(DEPTH):0]             sel_beat_count,
    output logic                               sel_whole
);
    localparam int LVL_W  = level_width(DEPTH);
    localparam int WORD_W = DATA_W + ID_W + 1;

    logic              push;
    logic              pop;
    logic [LVL_W-1:0]  level;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;
    occ_state_e        occ_state;

    assign push    = in_valid  && in_ready;
    assign pop     = out_valid && out_ready;
    assign wr_word = {in_id, in_last, in_data};

    pktcnt_store #(
        .DEPTH (DEPTH),
        .WORD_W(WORD_W)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .pop  (pop),
        .wdata(wr_word),
        .rdata(rd_word),
        .level(level)
    );

    pktcnt_occ_fsm #(
        .DEPTH(DEPTH),
        .LVL_W(LVL_W)
    ) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .level    (level),
        .state    (occ_state),
        .in_ready (in_ready),
        .out_valid(out_valid)
    );

    assign out_data = rd_word[DATA_W-1:0];
    assign out_last = rd_word[DATA_W];
    assign out_id   = rd_word[WORD_W-1:DATA_W+1];

    pktcnt_id_bank #(
        .ID_W (ID_W),
        .LVL_W(LVL_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_id  (in_id),
        .push_last(in_last),
        .pop      (pop),
        .pop_id   (out_id),
        .pop_last (out_last),
        .sel_id   (sel_id),
        .pop_first(out_first),
        .sel_pkt  (sel_pkt_count),
        .sel_beats(sel_beat_count),
        .sel_whole(sel_whole)
    );

endmodule

// File: rtl/pktcnt_fifo_chk.sv
module pktcnt_fifo_chk
    import pktcnt_pkg::*;
#(
    parameter int ID_W  = 2,
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    in_last,
    input logic [ID_W-1:0]         in_id,
    input logic                    out_first,
    input logic [ID_W-1:0]         out_id,
    input logic                    push,
    input logic                    pop,
    input logic [LVL_W-1:0]        level,
    input occ_state_e              occ_state,
    input logic [ID_W-1:0]         sel_id,
    input logic signed [LVL_W:0]   sel_pkt_count,
    input logic [LVL_W-1:0]        sel_beat_count
);
    localparam int PC_W = LVL_W + 1;

    // R1 / R11: handshake state agrees with pointer level
    p_ready_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (level != LVL_W'(DEPTH)));

    p_state_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_state == OCC_EMPTY) == (level == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !pop) |=> level == $past(level));

    p_pkt_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && in_last && in_id == sel_id && !(pop && out_first && out_id == in_id))
        |=> (sel_id != $past(sel_id)) ||
            (sel_pkt_count == $past(sel_pkt_count) + PC_W'(1)));

    p_pkt_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && out_first && out_id == sel_id && !(push && in_last && in_id == out_id))
        |=> (sel_id != $past(sel_id)) ||
            (sel_pkt_count == $past(sel_pkt_count) - PC_W'(1)));

    p_pkt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && in_last && pop && out_first && in_id == out_id && in_id == sel_id)
        |=> (sel_id != $past(sel_id)) || (sel_pkt_count == $past(sel_pkt_count)));

    p_beat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && in_id == out_id && in_id == sel_id)
        |=> (sel_id != $past(sel_id)) || (sel_beat_count == $past(sel_beat_count)));

    p_beat_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_beat_count <= level);

endmodule

bind pktcnt_fifo pktcnt_fifo_chk #(
    .ID_W (ID_W),
    .DEPTH(DEPTH),
    .LVL_W(LVL_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_last       (in_last),
    .in_id         (in_id),
    .out_first     (out_first),
    .out_id        (out_id),
    .push          (push),
    .pop           (pop),
    .level         (level),
    .occ_state     (occ_state),
    .sel_id        (sel_id),
    .sel_pkt_count (sel_pkt_count),
    .sel_beat_count(sel_beat_count)
);

// File: tb/pktcnt_fifo_test.sv
`timescale 1ns/10ps
module pktcnt_fifo_test;
    localparam int DW = 8;
    localparam int IW = 2;
    localparam int DEPTH = 8;
    localparam int NID = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [IW-1:0] in_id = '0, sel_id = '0;
    logic in_ready, out_valid, out_last, out_first, sel_whole;
    logic [DW-1:0] out_data;
    logic [IW-1:0] out_id;
    logic signed [4:0] sel_pkt_count;
    logic [3:0] sel_beat_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [10:0] q[$];
    int m_pkt [NID];
    int m_beat[NID];
    bit m_first[NID];

    always #4 clk = ~clk;

    pktcnt_fifo #(.DATA_W(DW), .ID_W(IW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_id(in_id),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_id(out_id), .out_first(out_first),
        .sel_id(sel_id), .sel_pkt_count(sel_pkt_count),
        .sel_beat_count(sel_beat_count), .sel_whole(sel_whole)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic model_clear();
        q.delete();
        for (int i = 0; i < NID; i++) begin
            m_pkt[i] = 0; m_beat[i] = 0; m_first[i] = 1'b1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // One clock: drive at falling edge, compare head, update model after rising edge.
    task automatic cycle(input bit v, input logic [7:0] d, input bit l,
                         input logic [1:0] id, input bit rdy);
        bit pf, pp;
        logic [10:0] h;
        @(negedge clk);
        in_valid = v; in_data = d; in_last = l; in_id = id; out_ready = rdy;
        #1;
        chk("R1 in_ready", int'(in_ready), int'(q.size() < DEPTH));
        chk("R1 out_valid", int'(out_valid), int'(q.size() > 0));
        if (out_valid && q.size() > 0) begin
            h = q[0];
            chk("R2 out_data", int'(out_data), int'(h[7:0]));
            chk("R2 out_last", int'(out_last), int'(h[8]));
            chk("R2 out_id", int'(out_id), int'(h[10:9]));
            chk("R4 out_first", int'(out_first), int'(m_first[h[10:9]]));
        end
        pf = v && in_ready;
        pp = rdy && out_valid;
        @(posedge clk);
        #1;
        in_valid = 1'b0; out_ready = 1'b0;
        if (pp && q.size() > 0) begin
            h = q.pop_front();
            m_beat[h[10:9]]--;
            if (m_first[h[10:9]]) m_pkt[h[10:9]]--;
            m_first[h[10:9]] = h[8];
        end
        if (pf) begin
            q.push_back({id, l, d});
            m_beat[id]++;
            if (l) m_pkt[id]++;
        end
    endtask

    // R9: read every tag's balances through the selection input.
    task automatic check_counts(input string tag);
        for (int i = 0; i < NID; i++) begin
            sel_id = IW'(i);
            #0.2;
            chk({tag, " R9 pkt"}, int'(sel_pkt_count), m_pkt[i]);
            chk({tag, " R9 beats"}, int'(sel_beat_count), m_beat[i]);
            chk({tag, " R9 whole"}, int'(sel_whole), int'(m_pkt[i] > 0));
        end
    endtask

    task automatic sel_expect(input string tag, input int id, input int pkt, input int beats);
        sel_id = IW'(id);
        #0.2;
        chk({tag, " pkt"}, int'(sel_pkt_count), pkt);
        chk({tag, " beats"}, int'(sel_beat_count), beats);
    endtask

    task automatic t_reset_state();
        chk("R10 out_valid after reset", int'(out_valid), 0);
        chk("R10 in_ready after reset", int'(in_ready), 1);
        check_counts("R10 reset");
    endtask

    task automatic t_single_packet();
        cycle(1, 8'h11, 0, 2'd1, 0);
        cycle(1, 8'h12, 0, 2'd1, 0);
        sel_expect("R5 before last", 1, 0, 2);
        cycle(1, 8'h13, 1, 2'd1, 0);
        sel_expect("R5 after last", 1, 1, 3);
        check_counts("R5");
        cycle(0, 8'h00, 0, 2'd0, 1);
        sel_expect("R6 after first leaves", 1, 0, 2);
        cycle(0, 8'h00, 0, 2'd0, 1);
        cycle(0, 8'h00, 0, 2'd0, 1);
        check_counts("R6 drained");
    endtask

    task automatic t_interleave();
        cycle(1, 8'h20, 0, 2'd0, 0);
        cycle(1, 8'h40, 0, 2'd2, 0);
        cycle(1, 8'h21, 1, 2'd0, 0);
        cycle(1, 8'h41, 0, 2'd2, 0);
        cycle(1, 8'h42, 1, 2'd2, 0);
        cycle(1, 8'h22, 1, 2'd0, 0);
        check_counts("R5 interleave");
        for (int k = 0; k < 6; k++) begin
            cycle(0, 8'h00, 0, 2'd0, 1);
            check_counts("R4 interleave drain");
        end
    endtask

    task automatic t_fill();
        for (int k = 0; k < 10; k++)
            cycle(1, 8'(8'h60 + k), k[0], 2'd3, 0);
        chk("R3 in_ready low when full", int'(in_ready), 0);
        check_counts("R3 overflow ignored");
        for (int k = 0; k < 10; k++)
            cycle(0, 8'h00, 0, 2'd0, 1);
        chk("R11 back to empty", int'(out_valid), 0);
        check_counts("R3 underflow ignored");
    endtask

    task automatic t_same_cycle();
        cycle(1, 8'h70, 1, 2'd3, 0);
        sel_expect("R5 one packet", 3, 1, 1);
        cycle(1, 8'h71, 1, 2'd3, 1);
        sel_expect("R7 R8 in and out together", 3, 1, 1);
        cycle(0, 8'h00, 0, 2'd0, 1);
        check_counts("R7 drained");
    endtask

    task automatic t_stream_through();
        cycle(1, 8'h80, 0, 2'd1, 0);
        cycle(0, 8'h00, 0, 2'd0, 1);
        sel_expect("R6 head left before tail", 1, -1, 0);
        cycle(1, 8'h81, 1, 2'd1, 0);
        sel_expect("R6 tail arrived", 1, 0, 1);
        cycle(0, 8'h00, 0, 2'd0, 1);
        check_counts("R6 stream-through");
    endtask

    task automatic t_reset_mid();
        cycle(1, 8'h90, 0, 2'd2, 0);
        cycle(1, 8'h91, 0, 2'd2, 0);
        cycle(0, 8'h00, 0, 2'd0, 1);
        do_reset();
        chk("R10 empty after mid reset", int'(out_valid), 0);
        check_counts("R10 mid reset");
        cycle(1, 8'h92, 0, 2'd2, 0);
        #1;
        chk("R10 first re-armed", int'(out_first), 1);
        cycle(0, 8'h00, 0, 2'd0, 1);
        check_counts("R10 after re-arm");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        t_reset_state();
        t_single_packet();
        t_interleave();
        t_fill();
        t_same_cycle();
        t_stream_through();
        t_reset_mid();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule